// File: doc/BRIEF.md
# Distributor Control Register Slice

This block holds the global control registers of an interrupt distributor. It decodes three 32-bit registers in a four-word window on a word-addressed register bus. Word 0 is a read/write control register that holds the global enable. Word 1 is a read-only geometry register that reports how many interrupts and CPUs exist. Word 2 is a read-only identification register. Word 3 reads as zero. When the global enable goes from off to on, the block emits a one-clock kick pulse, which tells the CPU interfaces to re-evaluate their pending interrupts.

A second, privileged host port sees the same registers and also acts as a version handshake. When the host writes the identification register with exactly its current value, the block sets a sticky flag. From then on, host writes aimed at the per-interrupt group arrays are allowed through the gate output. If the written value does not match, the host port reports an error and the flag does not change. The revision field of the identification value also sets how groups are reported: revision 1 forces every interrupt to group 0. The interrupt count, CPU count and revision come in on static inputs that are captured while reset is held.

Top module: `dist_ctrl_regs`

## Requirements
- R1: The word address selects the register: 0 is control, 1 is geometry, 2 is identification. Word 3 reads as all zeros on both ports.
- R2: Control bit 0 is the global enable, written from write-data bit 0 and read back in bit 0. All other control bits read as zero.
- R3: Geometry bits [4:0] read as ((shared interrupt count + 32) / 32) - 1. Bits [7:5] read as (CPU count - 1). Bits [31:8] read as zero.
- R4: Writes to words 1, 2 and 3 on the normal bus change no readback value and no output.
- R5: A write that takes the enable from 0 to 1 raises enable_kick in the cycle after the write, for exactly one clock. Writes that keep the enable at 1, keep it at 0 or clear it raise no kick.
- R6: The identification value has the product code in bits [31:24], the captured revision in bits [15:12] and the implementer code in bits [11:0]. All other bits are zero. force_group0 is 1 exactly when the captured revision equals 1.
- R7: A host write to word 2 whose data differs from the current identification value raises host_err in the next cycle, for one cycle. It does not change grp_writable.
- R8: A host write to word 2 whose data equals the identification value sets grp_writable in the next cycle. The flag stays set until reset, including across later mismatched writes.
- R9: grp_wr_allow follows host_grp_wr while grp_writable is 1 and stays 0 while grp_writable is 0.
- R10: Reset clears the enable, kick, host_err and grp_writable. The configuration inputs are captured while reset is high, and later changes to them do not alter the readback until the next reset.
- R11: A host write to word 0 has the same effect as a bus write. When both ports write word 0 in the same cycle, the host value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_spi_count | input | SPI_W | Number of shared interrupts (multiple of 32) |
| cfg_cpu_count | input | CPU_W | Number of online CPUs (1 to 8) |
| cfg_revision | input | 4 | Revision reported in the identification register |
| bus_valid | input | 1 | Normal bus access strobe |
| bus_write | input | 1 | Normal bus access is a write |
| bus_addr | input | WORD_AW | Normal bus word address |
| bus_wdata | input | 32 | Normal bus write data |
| bus_rdata | output | 32 | Normal bus read data (combinational from bus_addr) |
| host_valid | input | 1 | Host port access strobe |
| host_write | input | 1 | Host port access is a write |
| host_addr | input | WORD_AW | Host port word address |
| host_wdata | input | 32 | Host port write data |
| host_rdata | output | 32 | Host port read data (combinational from host_addr) |
| host_err | output | 1 | Rejected identification write, one cycle after the write |
| host_grp_wr | input | 1 | Host write request aimed at the group arrays |
| grp_wr_allow | output | 1 | Group-array write permitted this cycle |
| grp_writable | output | 1 | Sticky group-writable flag |
| dist_enable | output | 1 | Global distributor enable |
| enable_kick | output | 1 | One-clock pulse on enable rising |
| force_group0 | output | 1 | Report all interrupts as group 0 |

## Verification
The hardest state to reach is a mismatched host identification write that arrives after the group flag has already been set. A correct design must then report the error and still leave the flag set. The stimulus first rejects a wrong value while the flag is clear, then unlocks the flag with the exact value, and then repeats the wrong write. It also drives both ports to word 0 in the same cycle with opposite enable values. Finally it repeats the sequence after a second reset with a different configuration, which exercises the revision-1 group reporting and the values captured during reset.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_GEOM  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_NONE  = 2'd3
    } dctl_sel_e;

    typedef struct packed {
        logic              wr;
        dctl_sel_e         sel;
        logic [DATA_W-1:0] data;
    } dctl_acc_t;

    function automatic logic [DATA_W-1:0] build_ident(
        input logic [7:0]  product,
        input logic [3:0]  revision,
        input logic [11:0] implementer
    );
        return {product, 8'h00, revision, implementer};
    endfunction

    function automatic logic [DATA_W-1:0] read_select(
        input dctl_sel_e         sel,
        input logic              enable,
        input logic [DATA_W-1:0] geom,
        input logic [DATA_W-1:0] ident
    );
        logic [DATA_W-1:0] v;
        case (sel)
            SEL_CTRL:  v = {{(DATA_W-1){1'b0}}, enable};
            SEL_GEOM:  v = geom;
            SEL_IDENT: v = ident;
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dctl_decode.sv
module dctl_decode
    import dctl_pkg::*;
#(
    parameter int WORD_AW = 2
) (
    input  logic               valid,
    input  logic               write,
    input  logic [WORD_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output dctl_acc_t          acc
);
    always_comb begin
        acc.wr   = valid & write;
        acc.data = wdata;
        case (addr)
            WORD_AW'(0): acc.sel = SEL_CTRL;
            WORD_AW'(1): acc.sel = SEL_GEOM;
            WORD_AW'(2): acc.sel = SEL_IDENT;
            default:     acc.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/dctl_idregs.sv
module dctl_idregs
    import dctl_pkg::*;
#(
    parameter int          SPI_W       = 10,
    parameter int          CPU_W       = 4,
    parameter logic [7:0]  PRODUCT     = 8'h2D,
    parameter logic [11:0] IMPLEMENTER = 12'h5A1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SPI_W-1:0]  cfg_spi_count,
    input  logic [CPU_W-1:0]  cfg_cpu_count,
    input  logic [3:0]        cfg_revision,
    output logic [DATA_W-1:0] geom_val,
    output logic [DATA_W-1:0] ident_val,
    output logic              force_g0
);
    localparam int TOT_W = SPI_W + 1;
    localparam int GRP_W = TOT_W - 5;

    logic [TOT_W-1:0] total;
    logic [GRP_W-1:0] groups_m1;
    logic [4:0]       line_field;
    logic [2:0]       cpu_field;
    logic [4:0]       unused_total_low;

    assign total            = {1'b0, cfg_spi_count} + TOT_W'(32);
    assign groups_m1        = total[TOT_W-1:5] - GRP_W'(1);
    assign unused_total_low = total[4:0];
    assign line_field       = 5'(groups_m1);
    assign cpu_field        = 3'(cfg_cpu_count - CPU_W'(1));

    logic [DATA_W-1:0] geom_q;
    logic [DATA_W-1:0] ident_q;
    logic [3:0]        rev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            geom_q  <= {24'h0, cpu_field, line_field};
            ident_q <= build_ident(PRODUCT, cfg_revision, IMPLEMENTER);
            rev_q   <= cfg_revision;
        end
    end

    assign geom_val  = geom_q;
    assign ident_val = ident_q;
    assign force_g0  = (rev_q == 4'd1);

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(geom_q) && $stable(ident_q))) else $error("config changed"); // R10

    AST_REV_IN_IDENT: assert property (@(posedge clk) disable iff (rst)
        force_g0 |-> (ident_val[15:12] == 4'd1)) else $error("revision mismatch"); // R6
endmodule

// File: rtl/dctl_enable.sv
module dctl_enable
    import dctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dctl_acc_t bus_acc,
    input  dctl_acc_t host_acc,
    output logic      enable,
    output logic      kick
);
    logic bus_hit, host_hit, en_next;
    logic unused_bus_bits, unused_host_bits;

    assign unused_bus_bits  = ^bus_acc.data[DATA_W-1:1];
    assign unused_host_bits = ^host_acc.data[DATA_W-1:1];

    assign bus_hit  = bus_acc.wr  && (bus_acc.sel  == SEL_CTRL);
    assign host_hit = host_acc.wr && (host_acc.sel == SEL_CTRL);

    always_comb begin
        en_next = enable;
        if (host_hit)
            en_next = host_acc.data[0];
        else if (bus_hit)
            en_next = bus_acc.data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            kick   <= 1'b0;
        end else begin
            enable <= en_next;
            kick   <= ~enable & en_next;
        end
    end

    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        kick |=> !kick) else $error("kick longer than one clock"); // R5

    AST_KICK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        kick |-> (enable && !$past(enable))) else $error("kick without rising enable"); // R5

    AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
        host_hit |=> (enable == $past(host_acc.data[0]))) else $error("host control write lost"); // R11
endmodule

// File: rtl/dctl_hostgate.sv
module dctl_hostgate
    import dctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dctl_acc_t         host_acc,
    input  logic [DATA_W-1:0] ident_val,
    input  logic              grp_req,
    output logic              writable,
    output logic              err,
    output logic              grp_allow
);
    logic id_wr, id_match;

    assign id_wr    = host_acc.wr && (host_acc.sel == SEL_IDENT);
    assign id_match = (host_acc.data == ident_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            writable <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= id_wr & ~id_match;
            if (id_wr && id_match)
                writable <= 1'b1;
        end
    end

    assign grp_allow = grp_req & writable;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        writable |=> writable) else $error("group flag dropped"); // R8

    AST_ERR_NO_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (err && !$past(writable)) |-> !writable) else $error("mismatch unlocked groups"); // R7

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(id_wr)) else $error("error without identification write"); // R7
endmodule

// File: rtl/dist_ctrl_regs.sv
module dist_ctrl_regs
    import dctl_pkg::*;
#(
    parameter int          WORD_AW     = 2,
    parameter int          SPI_W       = 10,
    parameter int          CPU_W       = 4,
    parameter logic [7:0]  PRODUCT     = 8'h2D,
    parameter logic [11:0] IMPLEMENTER = 12'h5A1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SPI_W-1:0]   cfg_spi_count,
    input  logic [CPU_W-1:0]   cfg_cpu_count,
    input  logic [3:0]         cfg_revision,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [WORD_AW-1:0] bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [WORD_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_err,
    input  logic               host_grp_wr,
    output logic               grp_wr_allow,
    output logic               grp_writable,
    output logic               dist_enable,
    output logic               enable_kick,
    output logic               force_group0
);
    dctl_acc_t         bus_acc, host_acc;
    logic [DATA_W-1:0] geom_val, ident_val;

    dctl_decode #(.WORD_AW(WORD_AW)) u_dec_bus (
        .valid(bus_valid), .write(bus_write), .addr(bus_addr),
        .wdata(bus_wdata), .acc(bus_acc)
    );

    dctl_decode #(.WORD_AW(WORD_AW)) u_dec_host (
        .valid(host_valid), .write(host_write), .addr(host_addr),
        .wdata(host_wdata), .acc(host_acc)
    );

    dctl_idregs #(
        .SPI_W(SPI_W), .CPU_W(CPU_W),
        .PRODUCT(PRODUCT), .IMPLEMENTER(IMPLEMENTER)
    ) u_idregs (
        .clk(clk), .rst(rst),
        .cfg_spi_count(cfg_spi_count), .cfg_cpu_count(cfg_cpu_count),
        .cfg_revision(cfg_revision),
        .geom_val(geom_val), .ident_val(ident_val), .force_g0(force_group0)
    );

    dctl_enable u_enable (
        .clk(clk), .rst(rst),
        .bus_acc(bus_acc), .host_acc(host_acc),
        .enable(dist_enable), .kick(enable_kick)
    );

    dctl_hostgate u_gate (
        .clk(clk), .rst(rst),
        .host_acc(host_acc), .ident_val(ident_val), .grp_req(host_grp_wr),
        .writable(grp_writable), .err(host_err), .grp_allow(grp_wr_allow)
    );

    assign bus_rdata  = read_select(bus_acc.sel,  dist_enable, geom_val, ident_val);
    assign host_rdata = read_select(host_acc.sel, dist_enable, geom_val, ident_val);

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == WORD_AW'(3)) |-> (bus_rdata == 32'h0)) else $error("word 3 not zero"); // R1

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == WORD_AW'(0)) |-> (bus_rdata[31:1] == 31'h0)) else $error("control upper bits"); // R2

    AST_GATE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        grp_wr_allow |-> (grp_writable && host_grp_wr)) else $error("group write leaked"); // R9
endmodule

// File: tb/dist_ctrl_regs_bench.sv
module dist_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  cfg_spi_count = 10'd64;
    logic [3:0]  cfg_cpu_count = 4'd4;
    logic [3:0]  cfg_revision  = 4'd2;
    logic        bus_valid = 0, bus_write = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        host_valid = 0, host_write = 0;
    logic [1:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic        host_grp_wr = 0;
    logic [31:0] bus_rdata, host_rdata;
    logic        host_err, grp_wr_allow, grp_writable, dist_enable, enable_kick, force_group0;

    always #4 clk = ~clk;

    dist_ctrl_regs u_dist_ctrl_regs (
        .clk(clk), .rst(rst),
        .cfg_spi_count(cfg_spi_count), .cfg_cpu_count(cfg_cpu_count), .cfg_revision(cfg_revision),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_err(host_err),
        .host_grp_wr(host_grp_wr), .grp_wr_allow(grp_wr_allow), .grp_writable(grp_writable),
        .dist_enable(dist_enable), .enable_kick(enable_kick), .force_group0(force_group0)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural reference state
    int m_en, m_kick, m_err, m_flag, m_spi, m_cpu, m_rev;

    function automatic int m_geom();
        return ((m_spi + 32) / 32 - 1) + (m_cpu - 1) * 32;
    endfunction

    function automatic int m_ident();
        return 32'h2D00_0000 + m_rev * 4096 + 32'h5A1;
    endfunction

    function automatic int m_read(input int word);
        if (word == 0) return m_en;
        if (word == 1) return m_geom();
        if (word == 2) return m_ident();
        return 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "bus_rdata", bus_rdata, m_read(bus_addr));
        check(req, "host_rdata", host_rdata, m_read(host_addr));
        check(req, "dist_enable", dist_enable, m_en);
        check(req, "enable_kick", enable_kick, m_kick);
        check(req, "host_err", host_err, m_err);
        check(req, "grp_writable", grp_writable, m_flag);
        check(req, "grp_wr_allow", grp_wr_allow, (host_grp_wr && m_flag) ? 1 : 0);
        check(req, "force_group0", force_group0, (m_rev == 1) ? 1 : 0);
    endtask

    // one clock: drive at negedge, compare, then advance the model at posedge
    task automatic cyc(input string req,
                       input bit bv, input bit bw, input int ba, input int bd,
                       input bit hv, input bit hw, input int ha, input int hd, input bit hg);
        int nxt;
        bus_valid = bv; bus_write = bw; bus_addr = 2'(ba); bus_wdata = bd;
        host_valid = hv; host_write = hw; host_addr = 2'(ha); host_wdata = hd;
        host_grp_wr = hg;
        #1;
        compare_all(req);
        @(posedge clk);
        nxt = m_en;
        if (hv && hw && ha == 0) nxt = hd & 1;
        else if (bv && bw && ba == 0) nxt = bd & 1;
        m_kick = (m_en == 0 && nxt == 1) ? 1 : 0;
        m_en = nxt;
        m_err = 0;
        if (hv && hw && ha == 2) begin
            if (hd == m_ident()) m_flag = 1;
            else m_err = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string req, input int word);
        cyc(req, 0, 0, word, 0, 0, 0, word, 0, 0);
    endtask

    task automatic bus_wr(input string req, input int word, input int data);
        cyc(req, 1, 1, word, data, 0, 0, word, 0, 0);
    endtask

    task automatic host_wr(input string req, input int word, input int data);
        cyc(req, 0, 0, word, 0, 1, 1, word, data, 0);
    endtask

    task automatic do_reset(input int spi, input int cpu, input int rev);
        cfg_spi_count = 10'(spi); cfg_cpu_count = 4'(cpu); cfg_revision = 4'(rev);
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        m_en = 0; m_kick = 0; m_err = 0; m_flag = 0;
        m_spi = spi; m_cpu = cpu; m_rev = rev;
    endtask

    initial begin
        do_reset(64, 4, 2);
        // R10 reset state, R1/R3/R6 readback of every word
        for (int w = 0; w < 4; w++) idle("R10", w);
        idle("R3", 1);
        check("R3", "geometry literal", bus_rdata, 32'h0000_0062);
        idle("R6", 2);
        check("R6", "ident literal", bus_rdata, 32'h2D00_25A1);
        idle("R1", 3);
        check("R1", "word3 zero", bus_rdata, 0);

        // R5 / R2 enable and kick
        bus_wr("R2", 0, 32'hFFFF_FFFF);
        idle("R5", 0);
        check("R5", "kick after rise", enable_kick, 0);
        bus_wr("R5", 0, 1);
        idle("R5", 0);
        bus_wr("R5", 0, 0);
        idle("R5", 0);
        bus_wr("R5", 0, 0);
        bus_wr("R5", 0, 32'h0000_0003);
        idle("R2", 0);

        // R4 writes to read-only words
        bus_wr("R4", 1, 32'h1234_5678);
        bus_wr("R4", 2, 32'hDEAD_BEEF);
        bus_wr("R4", 3, 32'hFFFF_FFFF);
        for (int w = 0; w < 4; w++) idle("R4", w);

        // R11 host control and simultaneous writes
        host_wr("R11", 0, 0);
        idle("R11", 0);
        cyc("R11", 1, 1, 0, 0, 1, 1, 0, 1, 0);
        idle("R11", 0);
        cyc("R11", 1, 1, 0, 1, 1, 1, 0, 0, 0);
        idle("R11", 0);

        // R9 gate closed, R7 mismatch rejected
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        host_wr("R7", 2, 32'h2D00_15A1);
        idle("R7", 2);
        idle("R7", 2);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // R8 matching write unlocks, stays set through a later mismatch
        host_wr("R8", 2, 32'h2D00_25A1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        host_wr("R7", 2, 32'h0);
        idle("R8", 2);
        idle("R8", 2);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // normal-bus write of the exact value must not count as a handshake
        bus_wr("R4", 2, 32'h2D00_25A1);

        // R10 second reset with another configuration, then config changes ignored
        do_reset(224, 8, 1);
        for (int w = 0; w < 4; w++) idle("R10", w);
        idle("R3", 1);
        check("R3", "geometry literal 2", bus_rdata, 32'h0000_00E7);
        cfg_spi_count = 10'd0; cfg_cpu_count = 4'd1; cfg_revision = 4'd5;
        for (int w = 0; w < 4; w++) idle("R10", w);
        idle("R6", 2);
        check("R6", "ident literal 2", host_rdata, 32'h2D00_15A1);
        check("R6", "force_group0 rev1", force_group0, 1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        host_wr("R8", 2, 32'h2D00_15A1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        host_wr("R5", 0, 1);
        idle("R5", 0);
        idle("R5", 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule